// File: doc/BRIEF.md
# VEX Prefix and Operand-Byte Sequencer

This block sits in an instruction decode pipe right after the stage that has gathered the legacy prefixes and any REX byte. It takes instruction bytes one at a time over a valid/ready handshake. It waits in an idle state until a VEX lead byte appears. It then collects the rest of the vector-extension header, the opcode byte, and, only where the encoding calls for them, a ModR/M byte and a SIB byte. When the instruction header is complete, it raises a one-cycle completion pulse. That pulse carries either a decoded record or an undefined-opcode fault.

Sideband inputs describe the earlier prefix context: the captured REX value, flags for LOCK, F2 repeat, F3 repeat and 66 operand-size, the processor's code mode, and whether an address-size override was seen. The sideband is sampled when the lead byte is accepted. Illegal context is flagged on that lead byte. An illegal map-select field is flagged on the byte that carries it. A fault ends the instruction at once.

The sequencer states are Idle, Vex1, Vex2, Opcode, ModRM, Sib and Emit. The transitions are as follows. Idle goes to Vex1 on a lead byte with legal context, or to Emit on a lead byte with illegal context. Vex1 goes to Vex2 in the three-byte form, to Opcode in the two-byte form, or to Emit on an illegal map. Vex2 goes to Opcode. Opcode goes to ModRM, or to Emit when no ModR/M byte is needed. ModRM goes to Sib, or to Emit when no SIB byte is needed. Sib goes to Emit. Emit always goes back to Idle.

Top module: `vex_stream_decoder`

## Requirements
- R1: After reset, `out_done` is 0 and `in_ready` is 1.
- R2: In Idle, an accepted byte other than 0xC4 or 0xC5 is dropped: no completion pulse follows, and `in_ready` stays 1.
- R3: A nonzero `sb_rex` on an accepted lead byte ends the instruction. The completion pulse, with `out_fault`=1, comes in the cycle right after the lead byte, and `out_has_modrm`, `out_has_sib` and `out_has_vex2` are all 0.
- R4: Any of `sb_lock`, `sb_rep_f2`, `sb_rep_f3` or `sb_opsize` set on an accepted lead byte gives the same immediate fault as R3.
- R5: In the three-byte form (lead 0xC4), bits 4:0 of the next byte select the map. 1 gives map code 1 (0F), 2 gives code 2 (0F38), 3 gives code 3 (0F3A). Any other value faults in the cycle right after that byte. A record without a fault never carries map code 0.
- R6: In the two-byte form (lead 0xC5), the byte after the second VEX byte is the opcode. The map code is 1, and `out_has_vex2` is 0.
- R7: In the three-byte form, the byte after the map byte is reported as `out_vex2` with `out_has_vex2`=1, and the byte after that is the opcode.
- R8: A ModR/M byte follows the opcode in every case except map code 1 with opcode 0x77. In that case the record completes right after the opcode, with `out_has_modrm`=0.
- R9: A SIB byte follows the ModR/M byte only when addressing is not 16-bit, ModR/M bits 7:6 are not 11, and bits 2:0 are 100. `out_has_sib` implies `out_has_modrm`.
- R10: `sb_cpu_mode` uses code 0 for 16-bit, code 1 for 32-bit, and codes 2 and 3 for 64-bit. Addressing is 16-bit when the mode is 16-bit with no override, or 32-bit with `sb_addr_ovr`=1.
- R11: `out_done` lasts exactly one cycle and comes in the cycle after the final byte is accepted. During that cycle `in_ready` is 0, and the cycle after that the block is back in Idle with `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte can be taken this cycle |
| sb_rex | input | 8 | REX byte captured earlier (0 if none) |
| sb_lock | input | 1 | LOCK prefix seen |
| sb_rep_f2 | input | 1 | F2 repeat prefix seen |
| sb_rep_f3 | input | 1 | F3 repeat prefix seen |
| sb_opsize | input | 1 | 66 operand-size prefix seen |
| sb_cpu_mode | input | 2 | Code mode: 0 is 16-bit, 1 is 32-bit, 2 and 3 are 64-bit |
| sb_addr_ovr | input | 1 | Address-size override seen |
| out_done | output | 1 | One-cycle completion pulse |
| out_fault | output | 1 | Undefined-opcode fault (valid with out_done) |
| out_map | output | 2 | Map code: 1 is 0F, 2 is 0F38, 3 is 0F3A, 0 is none |
| out_lead | output | 8 | Lead byte |
| out_vex1 | output | 8 | Second VEX byte |
| out_vex2 | output | 8 | Third VEX byte (three-byte form) |
| out_opcode | output | 8 | Opcode byte |
| out_modrm | output | 8 | ModR/M byte |
| out_sib | output | 8 | SIB byte |
| out_has_vex2 | output | 1 | out_vex2 is valid |
| out_has_modrm | output | 1 | out_modrm is valid |
| out_has_sib | output | 1 | out_sib is valid |

## Verification
Every result is due exactly one cycle after the byte that ends the instruction is accepted. For a context fault, that byte is the lead byte. For a map fault, it is the map byte. Otherwise it is the opcode, ModR/M or SIB byte, whichever the expected byte count says comes last. The bench computes from the requirements alone which byte is last. It offers each byte at a falling edge, lets one rising edge take it, and samples at the next falling edge. At that point it requires the pulse to be absent after every earlier byte and present after the last. One cycle after the pulse, it confirms that the block is back in Idle.

// File: rtl/vexdec_pkg.sv
package vexdec_pkg;

    localparam int BYTE_W  = 8;
    localparam int MAPF_W  = 5;
    localparam int MODE_W  = 2;
    localparam int NPFX    = 4;

    localparam logic [BYTE_W-1:0] LEAD_2B  = 8'hC5;
    localparam logic [BYTE_W-1:0] LEAD_3B  = 8'hC4;
    localparam logic [BYTE_W-1:0] OPC_BARE = 8'h77;

    localparam logic [MODE_W-1:0] MODE_16 = 2'd0;
    localparam logic [MODE_W-1:0] MODE_32 = 2'd1;

    typedef enum logic [1:0] {
        MAP_NONE = 2'd0,
        MAP_0F   = 2'd1,
        MAP_0F38 = 2'd2,
        MAP_0F3A = 2'd3
    } vmap_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_VEX1  = 3'd1,
        ST_VEX2  = 3'd2,
        ST_OPC   = 3'd3,
        ST_MODRM = 3'd4,
        ST_SIB   = 3'd5,
        ST_EMIT  = 3'd6
    } dstate_e;

    typedef struct packed {
        logic              fault;
        vmap_e             map;
        logic [BYTE_W-1:0] lead;
        logic [BYTE_W-1:0] vex1;
        logic [BYTE_W-1:0] vex2;
        logic [BYTE_W-1:0] opcode;
        logic [BYTE_W-1:0] modrm;
        logic [BYTE_W-1:0] sib;
        logic              has_vex2;
        logic              has_modrm;
        logic              has_sib;
        logic              form3;
        logic              addr16;
    } vrec_t;

endpackage

// File: rtl/vexdec_prefix_check.sv
module vexdec_prefix_check
    import vexdec_pkg::*;
#(
    parameter int N_FLAGS = NPFX,
    parameter int REX_W   = BYTE_W
) (
    input  logic [REX_W-1:0]   rex_val,
    input  logic [N_FLAGS-1:0] pfx_flags,
    output logic               illegal
);
    logic [N_FLAGS:0] hit;

    assign hit[0] = |rex_val;

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        assign hit[g+1] = pfx_flags[g];
    end

    assign illegal = |hit;

endmodule

// File: rtl/vexdec_map_sel.sv
module vexdec_map_sel
    import vexdec_pkg::*;
#(
    parameter int FIELD_W = MAPF_W
) (
    input  logic [FIELD_W-1:0] field,
    output vmap_e              map,
    output logic               legal
);
    always_comb begin
        map   = MAP_NONE;
        legal = 1'b0;
        case (field)
            FIELD_W'(1): begin map = MAP_0F;   legal = 1'b1; end
            FIELD_W'(2): begin map = MAP_0F38; legal = 1'b1; end
            FIELD_W'(3): begin map = MAP_0F3A; legal = 1'b1; end
            default:     begin map = MAP_NONE; legal = 1'b0; end
        endcase
    end

endmodule

// File: rtl/vexdec_form_rules.sv
module vexdec_form_rules
    import vexdec_pkg::*;
#(
    parameter int OPC_W = BYTE_W,
    parameter int MW    = MODE_W
) (
    input  vmap_e            map,
    input  logic [OPC_W-1:0] opc,
    input  logic [1:0]       mod_f,
    input  logic [2:0]       rm_f,
    input  logic             addr16_q,
    input  logic [MW-1:0]    cpu_mode,
    input  logic             addr_ovr,
    output logic             need_modrm,
    output logic             need_sib,
    output logic             addr16_now
);
    localparam logic [1:0] MOD_REG = 2'b11;
    localparam logic [2:0] RM_SIB  = 3'b100;

    assign addr16_now = ((cpu_mode == MW'(MODE_16)) && !addr_ovr) ||
                        ((cpu_mode == MW'(MODE_32)) &&  addr_ovr);

    assign need_modrm = !((map == MAP_0F) && (opc == OPC_W'(OPC_BARE)));

    assign need_sib = !addr16_q && (mod_f != MOD_REG) && (rm_f == RM_SIB);

endmodule

// File: rtl/vex_stream_decoder.sv
module vex_stream_decoder
    import vexdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] sb_rex,
    input  logic              sb_lock,
    input  logic              sb_rep_f2,
    input  logic              sb_rep_f3,
    input  logic              sb_opsize,
    input  logic [MODE_W-1:0] sb_cpu_mode,
    input  logic              sb_addr_ovr,
    output logic              out_done,
    output logic              out_fault,
    output logic [1:0]        out_map,
    output logic [BYTE_W-1:0] out_lead,
    output logic [BYTE_W-1:0] out_vex1,
    output logic [BYTE_W-1:0] out_vex2,
    output logic [BYTE_W-1:0] out_opcode,
    output logic [BYTE_W-1:0] out_modrm,
    output logic [BYTE_W-1:0] out_sib,
    output logic              out_has_vex2,
    output logic              out_has_modrm,
    output logic              out_has_sib
);

    dstate_e state, nxt;
    vrec_t   rec;

    logic    acc;
    logic    is_lead;
    logic    pfx_bad;
    logic    map_ok;
    vmap_e   map_pick;
    logic    need_modrm;
    logic    need_sib;
    logic    addr16_now;

    assign acc     = in_valid && in_ready;
    assign is_lead = (in_byte == LEAD_2B) || (in_byte == LEAD_3B);

    vexdec_prefix_check #(.N_FLAGS(NPFX), .REX_W(BYTE_W)) u_pfx (
        .rex_val   (sb_rex),
        .pfx_flags ({sb_opsize, sb_rep_f3, sb_rep_f2, sb_lock}),
        .illegal   (pfx_bad)
    );

    vexdec_map_sel #(.FIELD_W(MAPF_W)) u_map (
        .field (in_byte[MAPF_W-1:0]),
        .map   (map_pick),
        .legal (map_ok)
    );

    vexdec_form_rules #(.OPC_W(BYTE_W), .MW(MODE_W)) u_rules (
        .map        (rec.map),
        .opc        (in_byte),
        .mod_f      (in_byte[7:6]),
        .rm_f       (in_byte[2:0]),
        .addr16_q   (rec.addr16),
        .cpu_mode   (sb_cpu_mode),
        .addr_ovr   (sb_addr_ovr),
        .need_modrm (need_modrm),
        .need_sib   (need_sib),
        .addr16_now (addr16_now)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transition logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (acc && is_lead) nxt = pfx_bad ? ST_EMIT : ST_VEX1;
            ST_VEX1:  if (acc) begin
                          if (rec.form3) nxt = map_ok ? ST_VEX2 : ST_EMIT;
                          else           nxt = ST_OPC;
                      end
            ST_VEX2:  if (acc) nxt = ST_OPC;
            ST_OPC:   if (acc) nxt = need_modrm ? ST_MODRM : ST_EMIT;
            ST_MODRM: if (acc) nxt = need_sib ? ST_SIB : ST_EMIT;
            ST_SIB:   if (acc) nxt = ST_EMIT;
            ST_EMIT:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Record capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec <= '0;
        end else if (acc) begin
            case (state)
                ST_IDLE: if (is_lead) begin
                    rec        <= '0;
                    rec.lead   <= in_byte;
                    rec.form3  <= (in_byte == LEAD_3B);
                    rec.fault  <= pfx_bad;
                    rec.addr16 <= addr16_now;
                end
                ST_VEX1: begin
                    rec.vex1 <= in_byte;
                    if (rec.form3) begin
                        if (map_ok) rec.map   <= map_pick;
                        else        rec.fault <= 1'b1;
                    end else begin
                        rec.map <= MAP_0F;
                    end
                end
                ST_VEX2: begin
                    rec.vex2     <= in_byte;
                    rec.has_vex2 <= 1'b1;
                end
                ST_OPC:   rec.opcode <= in_byte;
                ST_MODRM: begin
                    rec.modrm     <= in_byte;
                    rec.has_modrm <= 1'b1;
                end
                ST_SIB: begin
                    rec.sib     <= in_byte;
                    rec.has_sib <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready      = (state != ST_EMIT);
        out_done      = (state == ST_EMIT);
        out_fault     = rec.fault;
        out_map       = rec.map;
        out_lead      = rec.lead;
        out_vex1      = rec.vex1;
        out_vex2      = rec.vex2;
        out_opcode    = rec.opcode;
        out_modrm     = rec.modrm;
        out_sib       = rec.sib;
        out_has_vex2  = rec.has_vex2;
        out_has_modrm = rec.has_modrm;
        out_has_sib   = rec.has_sib;
    end

    // Assertions
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    p_ready_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> !in_ready);

    p_nonlead_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_valid && !is_lead) |=> !out_done);

    p_ctx_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && acc && is_lead &&
         (sb_lock || sb_rep_f2 || sb_rep_f3 || sb_opsize)) |=> (out_done && out_fault));

    p_fault_bare_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_fault) |-> (!out_has_modrm && !out_has_sib && !out_has_vex2));

    p_map_named_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !out_fault) |-> (out_map != MAP_NONE));

    p_two_byte_0f_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !out_fault && out_lead == LEAD_2B) |-> (out_map == MAP_0F && !out_has_vex2));

    p_bare_opcode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !out_fault && out_map == MAP_0F && out_opcode == OPC_BARE) |-> !out_has_modrm);

    p_sib_after_modrm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_has_sib) |-> out_has_modrm);

endmodule

// File: tb/vex_stream_decoder_tb_top.sv
module vex_stream_decoder_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       in_ready;
    logic [7:0] sb_rex;
    logic       sb_lock, sb_rep_f2, sb_rep_f3, sb_opsize;
    logic [1:0] sb_cpu_mode;
    logic       sb_addr_ovr;
    logic       out_done, out_fault;
    logic [1:0] out_map;
    logic [7:0] out_lead, out_vex1, out_vex2, out_opcode, out_modrm, out_sib;
    logic       out_has_vex2, out_has_modrm, out_has_sib;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vex_stream_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .sb_rex(sb_rex), .sb_lock(sb_lock),
        .sb_rep_f2(sb_rep_f2), .sb_rep_f3(sb_rep_f3), .sb_opsize(sb_opsize),
        .sb_cpu_mode(sb_cpu_mode), .sb_addr_ovr(sb_addr_ovr),
        .out_done(out_done), .out_fault(out_fault), .out_map(out_map),
        .out_lead(out_lead), .out_vex1(out_vex1), .out_vex2(out_vex2),
        .out_opcode(out_opcode), .out_modrm(out_modrm), .out_sib(out_sib),
        .out_has_vex2(out_has_vex2), .out_has_modrm(out_has_modrm),
        .out_has_sib(out_has_sib)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Offer one byte at a falling edge, let one rising edge take it,
    // return at the following falling edge.
    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic quiet(input string tag);
        chk(out_done == 1'b0, tag, "early done", int'(out_done), 0);
    endtask

    task automatic expect_end(input bit ef, input logic [1:0] em,
                              input logic [7:0] lead, v1, v2, opc, mrm, sb,
                              input bit h2, hm, hs, input string tag);
        chk(out_done == 1'b1, tag, "done", int'(out_done), 1);
        chk(in_ready == 1'b0, "R11", "ready in emit", int'(in_ready), 0);
        chk(out_fault == ef, tag, "fault", int'(out_fault), int'(ef));
        if (!ef) begin
            chk(out_map == em, tag, "map", int'(out_map), int'(em));
            chk(out_lead == lead && out_vex1 == v1, tag, "vex bytes",
                int'({out_lead, out_vex1}), int'({lead, v1}));
            chk(out_has_vex2 == h2 && (!h2 || out_vex2 == v2), tag, "vex2",
                int'({out_has_vex2, out_vex2}), int'({h2, v2}));
            chk(out_opcode == opc, tag, "opcode", int'(out_opcode), int'(opc));
            chk(out_has_modrm == hm && (!hm || out_modrm == mrm), tag, "modrm",
                int'({out_has_modrm, out_modrm}), int'({hm, mrm}));
            chk(out_has_sib == hs && (!hs || out_sib == sb), tag, "sib",
                int'({out_has_sib, out_sib}), int'({hs, sb}));
        end else begin
            chk(!out_has_modrm && !out_has_sib && !out_has_vex2, "R3", "fault flags",
                int'({out_has_vex2, out_has_modrm, out_has_sib}), 0);
        end
        @(posedge clk);
        @(negedge clk);
        chk(out_done == 1'b0 && in_ready == 1'b1, "R11", "back to idle",
            int'({out_done, in_ready}), 1);
    endtask

    task automatic run(input logic [7:0] lead, v1, v2, opc, mrm, sb, input string tag);
        bit         pfx, f3, mapok, nm, a16, ns;
        logic [1:0] em;
        pfx = (sb_rex != 8'h00) || sb_lock || sb_rep_f2 || sb_rep_f3 || sb_opsize;
        f3  = (lead == 8'hC4);
        if (f3) begin
            mapok = (v1[4:0] >= 5'd1) && (v1[4:0] <= 5'd3);
            em    = mapok ? v1[1:0] : 2'd0;
        end else begin
            mapok = 1'b1;
            em    = 2'd1;
        end
        nm  = !(em == 2'd1 && opc == 8'h77);
        a16 = (sb_cpu_mode == 2'd0 && !sb_addr_ovr) || (sb_cpu_mode == 2'd1 && sb_addr_ovr);
        ns  = nm && !a16 && (mrm[7:6] != 2'b11) && (mrm[2:0] == 3'b100);

        put(lead);
        if (pfx) begin
            expect_end(1'b1, 2'd0, lead, v1, v2, opc, mrm, sb, 0, 0, 0, tag);
            return;
        end
        quiet(tag);
        put(v1);
        if (!mapok) begin
            expect_end(1'b1, 2'd0, lead, v1, v2, opc, mrm, sb, 0, 0, 0, tag);
            return;
        end
        quiet(tag);
        if (f3) begin
            put(v2);
            quiet(tag);
        end
        put(opc);
        if (!nm) begin
            expect_end(1'b0, em, lead, v1, v2, opc, mrm, sb, f3, 0, 0, tag);
            return;
        end
        quiet(tag);
        put(mrm);
        if (!ns) begin
            expect_end(1'b0, em, lead, v1, v2, opc, mrm, sb, f3, 1, 0, tag);
            return;
        end
        quiet(tag);
        put(sb);
        expect_end(1'b0, em, lead, v1, v2, opc, mrm, sb, f3, 1, 1, tag);
    endtask

    task automatic clear_sb();
        sb_rex = 8'h00; sb_lock = 0; sb_rep_f2 = 0; sb_rep_f3 = 0; sb_opsize = 0;
        sb_cpu_mode = 2'd2; sb_addr_ovr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
        clear_sb();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(out_done == 1'b0, "R1", "done after reset", int'(out_done), 0);
        chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);

        // R2: non-lead bytes dropped in idle
        for (int b = 0; b < 256; b++) begin
            if (b != 8'hC4 && b != 8'hC5) begin
                put(8'(b));
                chk(out_done == 1'b0 && in_ready == 1'b1, "R2", "drop",
                    int'({out_done, in_ready}), 1);
            end
        end
        run(8'hC5, 8'hF8, 8'h00, 8'h10, 8'hC0, 8'h00, "R2");

        // R3: nonzero REX
        for (int r = 0; r < 17; r++) begin
            sb_rex = (r == 16) ? 8'h01 : 8'(8'h40 + r);
            run(8'hC5, 8'hF8, 8'h00, 8'h10, 8'hC0, 8'h00, "R3");
            run(8'hC4, 8'hE1, 8'h7D, 8'h10, 8'hC0, 8'h00, "R3");
        end
        clear_sb();

        // R4: LOCK / F2 / F3 / 66 each alone
        for (int k = 0; k < 4; k++) begin
            clear_sb();
            sb_lock = (k == 0); sb_rep_f2 = (k == 1); sb_rep_f3 = (k == 2); sb_opsize = (k == 3);
            run(8'hC5, 8'hF8, 8'h00, 8'h10, 8'hC0, 8'h00, "R4");
            run(8'hC4, 8'hE2, 8'h7D, 8'h10, 8'hC0, 8'h00, "R4");
        end
        clear_sb();

        // R5: every map-select value, two settings of the upper bits
        for (int f = 0; f < 32; f++) begin
            run(8'hC4, {3'b111, 5'(f)}, 8'h45, 8'h10, 8'hC0, 8'h00, "R5");
            run(8'hC4, {3'b010, 5'(f)}, 8'h45, 8'h11, 8'h05, 8'h00, "R5");
        end

        // R6 / R8: two-byte form, every opcode
        for (int o = 0; o < 256; o++)
            run(8'hC5, 8'hF8, 8'h00, 8'(o), 8'hC1, 8'h00, "R6 R8");

        // R7 / R8: three-byte form, every map and opcode
        for (int m = 1; m < 4; m++)
            for (int o = 0; o < 256; o++)
                run(8'hC4, {3'b111, 5'(m)}, 8'h7D, 8'(o), 8'hD2, 8'h00, "R7 R8");

        // R9 / R10: every ModR/M value under each mode and override
        for (int md = 0; md < 3; md++)
            for (int ov = 0; ov < 2; ov++) begin
                sb_cpu_mode = 2'(md);
                sb_addr_ovr = ov[0];
                for (int x = 0; x < 256; x++)
                    run(8'hC5, 8'hF8, 8'h00, 8'h58, 8'(x), 8'h24, "R9 R10");
            end
        clear_sb();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule